// File: doc/BRIEF.md
# Timer with Shared Prescaler

This block is an 8-bit timer/counter that shares one programmable prescaler with a watchdog. One option bit decides where the prescaler sits. It can sit in front of the timer and divide the timer's input events. It can instead sit behind the watchdog and divide the raw watchdog pulses before they become the watchdog tick. The prescaler serves only one of the two at a time. The side that does not own it runs undivided.

The timer counts one of two sources. The first is the instruction-cycle enable. The second is edges on an external clock pin, and an option bit picks whether rising or falling edges count. External events pass through the prescaler first. They are then re-timed to the instruction cycle, so a count lands two instruction cycles after the prescaled edge. A wrap from all ones to zero sets a sticky flag. Software loads the counter and the option bits through plain write strobes that share one data bus. Software reads the counter and the options back on output pins. While sleep is high the timer and its prescaler are frozen. The watchdog path keeps running during sleep.

Top module: `tsp_timer`

## Requirements
- R1: After reset the counter reads 0, the overflow flag is 0 and the option field reads 6'h3F.
- R2: With the source bit (option bit 5) at 0 and the prescaler owned by the watchdog (option bit 3 at 1), the counter rises by one on every instruction-cycle enable.
- R3: With option bit 3 at 0, the prescaler sits in front of the timer. The counter then rises once every 2^(ratio+1) source events, where ratio is option bits 2:0. The first increment comes on the 2^(ratio+1)-th event after the prescaler was cleared.
- R4: With option bit 5 at 1, the source is the external pin. Option bit 4 at 0 counts rising edges and at 1 counts falling edges. The pin passes through a two-flop synchronizer before edge detection.
- R5: An external event that leaves the prescaler reaches the counter on the second instruction-cycle enable after it. Events that leave the prescaler between two enables merge into one.
- R6: An increment from 8'hFF wraps the counter to 0 and sets the overflow flag. The flag stays set until a flag-clear strobe. If a set and a clear happen in the same cycle, the set wins.
- R7: A counter write loads the data bus. It also blocks increments on the next two instruction-cycle enables. When the prescaler is owned by the timer, the write clears the prescaler. A write takes priority over an increment in the same cycle.
- R8: When the watchdog owns the prescaler, the watchdog tick fires on one raw pulse in every 2^ratio raw pulses. Otherwise the tick equals the raw pulse.
- R9: A write to the options that changes bit 3 clears the prescaler, so counting restarts from zero on the new side.
- R10: While sleep is high, the counter, the timer-side prescaler and the re-timing stages hold their values. A prescaler owned by the watchdog keeps dividing.
- R11: An option write stores data bits 5:0, and the option output reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en | input | 1 | One-clock pulse per instruction cycle |
| sleep | input | 1 | Freezes the timer side while high |
| ext_clk | input | 1 | External count pin, asynchronous |
| wdt_raw | input | 1 | One-clock raw watchdog pulse |
| wr_cnt | input | 1 | Load counter from wr_data |
| wr_opt | input | 1 | Load options from wr_data[5:0] |
| wr_data | input | 8 | Write data bus |
| flag_clr | input | 1 | Clear the overflow flag |
| cnt_q | output | 8 | Counter value |
| opt_q | output | 6 | Options: [5] external source, [4] falling edge, [3] prescaler to watchdog, [2:0] ratio |
| ovf_flag | output | 1 | Sticky overflow flag |
| wdt_tick | output | 1 | Watchdog tick, divided or passed through |

## Verification
The bench builds the block with its default parameters. These are an 8-bit counter, an 8-bit prescaler, a 3-bit ratio, a two-flop pin synchronizer and a two-cycle write hold-off. With these values a wrap comes within a few hundred cycles of a load near 8'hFF. Every ratio code, including the full divide-by-256 on the timer side, also fits in a short run. The narrow hold-off and synchronizer depths make each increment land in a cycle that can be counted by hand. The reference model can therefore pin down every re-timed external count, and the model is compared against the design on every clock.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  localparam int RATIO_W = 3;

  typedef struct packed {
    logic               src_ext;
    logic               edge_fall;
    logic               pre_wdt;
    logic [RATIO_W-1:0] ratio;
  } tsp_opt_t;

  localparam int OPT_W = $bits(tsp_opt_t);
  localparam tsp_opt_t OPT_RESET = '{src_ext: 1'b1, edge_fall: 1'b1,
                                     pre_wdt: 1'b1, ratio: '1};
endpackage

// File: rtl/tsp_pin_edge.sv
module tsp_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[i] <= 1'b0;
      else if (i == 0) sync_q[i] <= pin;
      else sync_q[i] <= sync_q[(i > 0) ? i - 1 : 0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else last_q <= sync_q[STAGES-1];
  end

  assign edge_o = fall ? (last_q & ~sync_q[STAGES-1])
                       : (~last_q & sync_q[STAGES-1]);
endmodule

// File: rtl/tsp_prescaler.sv
module tsp_prescaler #(
  parameter int PRE_W   = 8,
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               adv,
  input  logic               to_wdt,
  input  logic [RATIO_W-1:0] ratio,
  output logic               hit
);
  localparam int SH_W = RATIO_W + 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic [SH_W-1:0]  shift;

  // Timer side divides by 2^(ratio+1), watchdog side by 2^ratio.
  assign shift = {1'b0, ratio} + {{RATIO_W{1'b0}}, ~to_wdt};
  assign mask  = ~({PRE_W{1'b1}} << shift);
  assign hit   = adv & ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (clr) pre_q <= '0;
    else if (adv) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tsp_tick_sync.sv
module tsp_tick_sync #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic run,
  input  logic ext_mode,
  input  logic evt_in,
  input  logic load,
  output logic inc_o
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  logic              pend_q;
  logic              stage_q;
  logic [HOLD_W-1:0] hold_q;
  logic              ext_evt;
  logic              inc_raw;

  assign ext_evt = evt_in & ext_mode;
  assign inc_raw = ext_mode ? (cyc_en & stage_q) : evt_in;
  assign inc_o   = run & inc_raw & (hold_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      stage_q <= 1'b0;
    end else if (run) begin
      if (cyc_en) begin
        stage_q <= pend_q | ext_evt;
        pend_q  <= 1'b0;
      end else begin
        pend_q  <= pend_q | ext_evt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (load) hold_q <= HOLD_W'(HOLD_CYC);
    else if (cyc_en && run && hold_q != '0) hold_q <= hold_q - 1'b1;
  end
endmodule

// File: rtl/tsp_timer.sv
module tsp_timer
  import tsp_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PRE_W     = 8,
  parameter int PIN_SYNC  = 2,
  parameter int HOLD_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             sleep,
  input  logic             ext_clk,
  input  logic             wdt_raw,
  input  logic             wr_cnt,
  input  logic             wr_opt,
  input  logic [7:0]       wr_data,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [OPT_W-1:0] opt_q,
  output logic             ovf_flag,
  output logic             wdt_tick
);
  tsp_opt_t   opt_r;
  logic       pin_edge;
  logic       src_evt;
  logic       pre_adv;
  logic       pre_clr;
  logic       pre_hit;
  logic       tmr_evt;
  logic       inc;
  logic       wrap;
  logic [CNT_W-1:0] cnt_r;
  logic       flag_r;

  tsp_pin_edge #(.STAGES(PIN_SYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_clk),
    .fall(opt_r.edge_fall), .edge_o(pin_edge)
  );

  assign src_evt = opt_r.src_ext ? pin_edge : cyc_en;
  assign pre_adv = opt_r.pre_wdt ? wdt_raw : (src_evt & ~sleep);
  assign pre_clr = (wr_cnt & ~opt_r.pre_wdt) |
                   (wr_opt & (wr_data[3] != opt_r.pre_wdt));

  tsp_prescaler #(.PRE_W(PRE_W), .RATIO_W(RATIO_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(pre_clr), .adv(pre_adv),
    .to_wdt(opt_r.pre_wdt), .ratio(opt_r.ratio), .hit(pre_hit)
  );

  assign tmr_evt  = opt_r.pre_wdt ? (src_evt & ~sleep) : pre_hit;
  assign wdt_tick = opt_r.pre_wdt ? pre_hit : wdt_raw;

  tsp_tick_sync #(.HOLD_CYC(HOLD_CYC)) u_sync (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .run(~sleep),
    .ext_mode(opt_r.src_ext), .evt_in(tmr_evt), .load(wr_cnt), .inc_o(inc)
  );

  assign wrap = inc & ~wr_cnt & (&cnt_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opt_r <= OPT_RESET;
    else if (wr_opt) opt_r <= tsp_opt_t'(wr_data[OPT_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_r <= '0;
    else if (wr_cnt) cnt_r <= wr_data[CNT_W-1:0];
    else if (inc) cnt_r <= cnt_r + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_r <= 1'b0;
    else if (wrap) flag_r <= 1'b1;
    else if (flag_clr) flag_r <= 1'b0;
  end

  assign cnt_q    = cnt_r;
  assign opt_q    = opt_r;
  assign ovf_flag = flag_r;
endmodule

// File: rtl/tsp_timer_chk.sv
module tsp_timer_chk #(
  parameter int CNT_W = 8,
  parameter int OPT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep,
  input logic             wr_cnt,
  input logic [7:0]       wr_data,
  input logic             flag_clr,
  input logic             wdt_raw,
  input logic [CNT_W-1:0] cnt_q,
  input logic [OPT_W-1:0] opt_q,
  input logic             ovf_flag,
  input logic             wdt_tick
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_cnt) && (cnt_q != $past(cnt_q))) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R2
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_cnt) && ($past(cnt_q) == '1) && (cnt_q == '0)) |-> ovf_flag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag); // R6
  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wr_data[CNT_W-1:0]))); // R7
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !wr_cnt) |=> $stable(cnt_q)); // R10
  AST_WDT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_q[3] |-> (wdt_tick == wdt_raw)); // R8
endmodule

bind tsp_timer tsp_timer_chk #(.CNT_W(CNT_W), .OPT_W(tsp_pkg::OPT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .wr_cnt(wr_cnt), .wr_data(wr_data),
  .flag_clr(flag_clr), .wdt_raw(wdt_raw), .cnt_q(cnt_q), .opt_q(opt_q),
  .ovf_flag(ovf_flag), .wdt_tick(wdt_tick)
);

// File: tb/sim_tsp_timer.sv
module sim_tsp_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_en = 1'b0, sleep = 1'b0, ext_clk = 1'b0, wdt_raw = 1'b0;
  logic wr_cnt = 1'b0, wr_opt = 1'b0, flag_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] cnt_q;
  logic [5:0] opt_q;
  logic ovf_flag, wdt_tick;

  always #2 clk = ~clk;

  tsp_timer u0 (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .sleep(sleep), .ext_clk(ext_clk),
    .wdt_raw(wdt_raw), .wr_cnt(wr_cnt), .wr_opt(wr_opt), .wr_data(wr_data),
    .flag_clr(flag_clr), .cnt_q(cnt_q), .opt_q(opt_q), .ovf_flag(ovf_flag),
    .wdt_tick(wdt_tick)
  );

  int checks = 0, errors = 0, cycles = 0, phase = 0;
  string cur_req = "R1";
  bit ext_run = 0, wdt_run = 0;
  int ext_half = 8;

  // Behavioural reference state
  int m_cnt, m_flag, m_pre, m_hold, m_pend, m_sync, e1, e2, e3;
  int m_ext, m_fall, m_wdt, m_ratio;

  function automatic int pow2(int k); return 1 << k; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_flag = 0; m_pre = 0; m_hold = 0; m_pend = 0; m_sync = 0;
      e1 = 0; e2 = 0; e3 = 0; m_ext = 1; m_fall = 1; m_wdt = 1; m_ratio = 7;
    end else begin
      int edge_seen, src, tevt, npre, inc, nwdt;
      edge_seen = m_fall ? (e3 == 1 && e2 == 0) : (e3 == 0 && e2 == 1);
      src = m_ext ? edge_seen : int'(cyc_en);
      tevt = 0; npre = m_pre;
      if (m_wdt) begin
        if (wdt_raw) npre = (m_pre + 1) % 256;
        if (!sleep) tevt = src;
      end else if (!sleep && src) begin
        if (m_pre % pow2(m_ratio + 1) == pow2(m_ratio + 1) - 1) tevt = 1;
        npre = (m_pre + 1) % 256;
      end
      if (m_ext) inc = (cyc_en && m_sync && !sleep);
      else inc = tevt;
      if (m_hold > 0) inc = 0;
      if (!sleep) begin
        if (cyc_en) begin
          m_sync = (m_pend || (tevt && m_ext)) ? 1 : 0;
          m_pend = 0;
        end else if (tevt && m_ext) m_pend = 1;
        if (cyc_en && m_hold > 0) m_hold--;
      end
      e3 = e2; e2 = e1; e1 = ext_clk;
      if (wr_cnt) begin
        m_cnt = wr_data; m_hold = 2;
        if (!m_wdt) npre = 0;
        if (flag_clr) m_flag = 0;
      end else begin
        if (flag_clr) m_flag = 0;
        if (inc) begin
          if (m_cnt == 255) m_flag = 1;
          m_cnt = (m_cnt + 1) % 256;
        end
      end
      if (wr_opt) begin
        nwdt = wr_data[3];
        if (nwdt != m_wdt) npre = 0;
        m_ext = wr_data[5]; m_fall = wr_data[4]; m_wdt = nwdt; m_ratio = wr_data[2:0];
      end
      m_pre = npre;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic compare();
    int exp_tick;
    if (m_wdt) exp_tick = (wdt_raw && (m_pre % pow2(m_ratio) == pow2(m_ratio) - 1)) ? 1 : 0;
    else exp_tick = wdt_raw;
    chk(cur_req, "cnt_q", cnt_q, m_cnt);
    chk(cur_req, "ovf_flag", ovf_flag, m_flag);
    chk(cur_req, "opt_q", opt_q, {m_ext[0], m_fall[0], m_wdt[0], m_ratio[2:0]});
    chk(cur_req == "R8" || cur_req == "R9" ? cur_req : "R8", "wdt_tick", wdt_tick, exp_tick);
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      cycles++;
      if (rst_n) compare();
      wr_cnt = 0; wr_opt = 0; flag_clr = 0;
      phase++;
      cyc_en = (phase % 4 == 0);
      if (ext_run && (phase % ext_half == 0)) ext_clk = ~ext_clk;
      wdt_raw = wdt_run && (phase % 3 == 0);
    end
  endtask

  task automatic write_opt(logic [7:0] v);
    step(1); wr_opt = 1; wr_data = v;
  endtask

  task automatic write_cnt(logic [7:0] v);
    step(1); wr_cnt = 1; wr_data = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    step(1);
    // R1: reset values at the ports
    cur_req = "R1";
    chk("R1", "reset cnt", cnt_q, 0);
    chk("R1", "reset flag", ovf_flag, 0);
    chk("R1", "reset opt", opt_q, 6'h3F);

    // R11 / R2: internal source, prescaler on watchdog, ratio 0
    cur_req = "R11";
    write_opt(8'h08);
    step(2);
    chk("R11", "opt readback", opt_q, 6'h08);
    cur_req = "R2";
    write_cnt(8'h00);
    step(60);
    chk("R2", "counter advanced", int'(cnt_q > 8'd10), 1);

    // R3 / R9: prescaler moved to the timer, ratio 2 then ratio 0
    cur_req = "R9";
    write_opt(8'h02);
    cur_req = "R3";
    write_cnt(8'h00);
    step(300);
    write_opt(8'h00);
    step(100);
    write_opt(8'h07);
    write_cnt(8'h00);
    step(1100);
    chk("R3", "div256 slow", int'(cnt_q <= 8'd2), 1);

    // R4: external pin, rising then falling edges, prescaler on watchdog
    cur_req = "R4";
    ext_run = 1;
    write_opt(8'h28);
    write_cnt(8'h00);
    step(400);
    write_opt(8'h38);
    step(400);

    // R5: external pin through the timer-side prescaler, and fast pin merging
    cur_req = "R5";
    write_opt(8'h20);
    write_cnt(8'h10);
    step(400);
    ext_half = 2;
    write_opt(8'h28);
    step(200);
    ext_half = 8;
    ext_run = 0;

    // R6: wrap and sticky flag, clear held during a wrap
    cur_req = "R6";
    write_opt(8'h08);
    write_cnt(8'hFC);
    step(40);
    chk("R6", "flag set after wrap", ovf_flag, 1);
    step(20);
    chk("R6", "flag sticky", ovf_flag, 1);
    step(1); flag_clr = 1;
    step(2);
    chk("R6", "flag cleared", ovf_flag, 0);
    write_cnt(8'hFE);
    for (int i = 0; i < 30; i++) begin step(1); flag_clr = 1; end
    step(5);

    // R7: writes while counting, with prescaler on each side
    cur_req = "R7";
    write_cnt(8'h40);
    step(3);
    write_cnt(8'h50);
    step(40);
    write_opt(8'h01);
    write_cnt(8'h60);
    step(5);
    write_cnt(8'h70);
    step(60);

    // R8 / R9: watchdog division, ratios 2 and 0, then pass-through
    cur_req = "R8";
    wdt_run = 1;
    write_opt(8'h0A);
    step(200);
    write_opt(8'h08);
    step(60);
    write_opt(8'h02);
    step(60);
    cur_req = "R9";
    write_opt(8'h0B);
    step(150);
    write_opt(8'h03);
    step(150);

    // R10: sleep freezes the timer, watchdog side keeps dividing
    cur_req = "R10";
    write_opt(8'h09);
    step(20);
    sleep = 1;
    step(2);
    begin
      int held;
      held = cnt_q;
      step(80);
      chk("R10", "cnt frozen", cnt_q, held);
    end
    sleep = 0;
    step(40);
    write_opt(8'h00);
    step(10);
    sleep = 1;
    step(80);
    sleep = 0;
    step(40);
    wdt_run = 0;
    step(5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule